// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small nonvolatile memory that a host reaches over a three-wire synchronous serial link. The link has a select line, a serial clock, a data input, and a data output that can be released to high impedance. A static organization input gives one of two views of the same 8192 storage bits: 512 words of 16 bits, or 1024 words of 8 bits. The host shifts in a start bit, a two-bit opcode, an address field and, for data-carrying commands, a data word. The block reads one word or a continuous run of words. It also writes or clears one word, writes or clears every word, and sets or clears a software write-enable latch.

Programming is self-timed. It begins when the select line drops after a complete programming command and lasts a fixed number of system-clock cycles. While the select line is high during that time, the data output reports busy as 0 and ready as 1. Shifting a 1 into the data input releases the output. The storage is a register array inside the block. The serial pins are sampled by the system clock, so the serial clock must be several system-clock cycles slower.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the data output is released (do_oe = 0), the write-enable latch is clear, and every stored bit reads 1.
- R2: While the select line is high, 0 bits before the start bit are ignored. A command is a 1 start bit, a two-bit opcode, then an address field sent MSB first: 10 bits with org = 1 (x16) or 11 bits with org = 0 (x8). The MSB of the address field is ignored. Data input is taken at each rising edge of the serial clock.
- R3: Opcode 10 is a read. After the last address bit, the output is driven with a 0. The addressed word then follows MSB first, with each bit presented after a rising edge of the serial clock.
- R4: While select stays high during a read, the clocks that follow return the next words with no leading 0. The address after the last word (511 in x16, 1023 in x8) is 0.
- R5: Opcode 00 with the two top address-field bits at 11 sets the write-enable latch, and at 00 clears it. Programming commands issued while the latch is clear change nothing and start no busy period.
- R6: Opcode 01 followed by a data word (16 bits in x16, 8 bits in x8, MSB first) replaces the addressed word. No prior clear is needed. Programming starts when select falls after the last data bit.
- R7: Opcode 11 sets the addressed word to all ones. Opcode 00 with top bits 10 sets every word to all ones. Opcode 00 with top bits 01, followed by a data word, writes that word to every location.
- R8: From the start of programming, the output is driven low while select is high. It turns high after the programming period ends. A command shifted in during programming has no effect.
- R9: A 1 shifted in while the busy/ready status is shown releases the output after the next falling edge of the serial clock.
- R10: Dropping select before a command is complete abandons it with no effect on the storage or the status output.
- R11: In x16, word a holds x8 byte 2a as its high half and byte 2a+1 as its low half.
- R12: The output is released whenever select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Select line, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| org | input | 1 | Organization: 1 = 512 x 16, 0 = 1024 x 8 |
| do_out | output | 1 | Serial data out value |
| do_oe | output | 1 | Serial data out drive enable (0 = high impedance) |

## Verification
The assertions assume that the serial clock high and low phases each last at least four system-clock cycles. They also assume that the data input is stable around each rising serial-clock edge and that org changes only while no command or programming cycle is in progress. The bench drives every pin from tasks that hold each level for four system-clock cycles and changes org only between transactions, so each serial edge is seen once. Random and directed transactions run against a byte-level model. The busy window is made long enough that a complete command fits inside it.

// File: rtl/uw_pkg.sv
package uw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_DATA,
        S_WAITCS,
        S_BUSY,
        S_READ,
        S_SKIP
    } uw_state_e;

    typedef enum logic [1:0] {
        OP_WORD_WR,
        OP_WORD_CLR,
        OP_ALL_CLR,
        OP_ALL_WR
    } uw_prog_e;

    localparam int NARROW_W = 8;
    localparam int WIDE_W   = 16;
endpackage

// File: rtl/uw_pins.sv
module uw_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise,
    output logic sk_fall
);
    typedef struct packed {
        logic [1:0] cs_p;
        logic [2:0] sk_p;
        logic [1:0] di_p;
    } pins_t;

    pins_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.cs_p = {r_q.cs_p[0], cs};
        r_d.sk_p = {r_q.sk_p[1:0], sk};
        r_d.di_p = {r_q.di_p[0], di};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cs_s    = r_q.cs_p[1];
    assign di_s    = r_q.di_p[1];
    assign sk_rise = r_q.sk_p[1] & ~r_q.sk_p[2];
    assign sk_fall = ~r_q.sk_p[1] & r_q.sk_p[2];
endmodule

// File: rtl/uw_timer.sv
module uw_timer #(
    parameter int WCYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int TW = $clog2(WCYCLES + 1);

    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = TW'(WCYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == TW'(1));
endmodule

// File: rtl/uw_array.sv
module uw_array
    import uw_pkg::*;
#(
    parameter int ABITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             org,
    input  logic             we,
    input  uw_prog_e         op,
    input  logic [ABITS-1:0] waddr,
    input  logic [15:0]      wdata,
    input  logic [ABITS-1:0] raddr,
    output logic [15:0]      rdata
);
    localparam int DEPTH = 1 << ABITS;

    logic [NARROW_W-1:0] mem [DEPTH];
    logic [ABITS-1:0]    w_hi, w_lo, r_hi, r_lo;

    assign w_hi = {waddr[ABITS-2:0], 1'b0};
    assign w_lo = {waddr[ABITS-2:0], 1'b1};
    assign r_hi = {raddr[ABITS-2:0], 1'b0};
    assign r_lo = {raddr[ABITS-2:0], 1'b1};

    always_comb begin
        if (org) rdata = {mem[r_hi], mem[r_lo]};
        else     rdata = {8'h00, mem[raddr]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            case (op)
                OP_WORD_WR: begin
                    if (org) begin
                        mem[w_hi] <= wdata[15:8];
                        mem[w_lo] <= wdata[7:0];
                    end else begin
                        mem[waddr] <= wdata[7:0];
                    end
                end
                OP_WORD_CLR: begin
                    if (org) begin
                        mem[w_hi] <= 8'hFF;
                        mem[w_lo] <= 8'hFF;
                    end else begin
                        mem[waddr] <= 8'hFF;
                    end
                end
                OP_ALL_CLR: begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                end
                default: begin
                    for (int i = 0; i < DEPTH; i++)
                        mem[i] <= (org && !i[0]) ? wdata[15:8] : wdata[7:0];
                end
            endcase
        end
    end
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
    import uw_pkg::*;
#(
    parameter int ABITS   = 10,
    parameter int WCYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org,
    output logic do_out,
    output logic do_oe
);
    localparam int FL8  = ABITS + 1;
    localparam int FL16 = ABITS;
    localparam int SHW  = 2 + FL8;
    localparam int CMAX = (SHW > WIDE_W) ? SHW : WIDE_W;
    localparam int CW   = $clog2(CMAX) + 1;

    typedef struct packed {
        uw_state_e        st;
        logic [CW-1:0]    cnt;
        logic [SHW-1:0]   sh;
        uw_prog_e         op;
        logic [ABITS-1:0] addr;
        logic [15:0]      wdata;
        logic             wen;
        logic             status;
        logic             rel;
        logic             dummy;
        logic [3:0]       rbit;
        logic [ABITS-1:0] raddr;
    } core_t;

    core_t r_q, r_d;

    logic cs_s, di_s, sk_rise, sk_fall;
    logic tmr_start, tmr_done, mem_we;
    logic [15:0] rdata;
    logic [SHW-1:0] full;
    logic [1:0] opc, spc;
    logic [ABITS-1:0] caddr, nxt_raddr;
    int fl, ww;
    logic in_read, in_busy, in_cmd;

    uw_pins u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (cs),
        .sk     (sk),
        .di     (di),
        .cs_s   (cs_s),
        .di_s   (di_s),
        .sk_rise(sk_rise),
        .sk_fall(sk_fall)
    );

    uw_timer #(.WCYCLES(WCYCLES)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .done (tmr_done)
    );

    uw_array #(.ABITS(ABITS)) u_arr (
        .clk  (clk),
        .rst_n(rst_n),
        .org  (org),
        .we   (mem_we),
        .op   (r_q.op),
        .waddr(r_q.addr),
        .wdata(r_q.wdata),
        .raddr(r_q.raddr),
        .rdata(rdata)
    );

    always_comb begin
        fl    = org ? FL16 : FL8;
        ww    = org ? WIDE_W : NARROW_W;
        full  = {r_q.sh[SHW-2:0], di_s};
        opc   = org ? full[FL16+1:FL16] : full[FL8+1:FL8];
        spc   = org ? full[FL16-1:FL16-2] : full[FL8-1:FL8-2];
        caddr = org ? {1'b0, full[ABITS-2:0]} : full[ABITS-1:0];
        nxt_raddr = r_q.raddr + 1'b1;
        if (org) nxt_raddr[ABITS-1] = 1'b0;
    end

    always_comb begin
        r_d       = r_q;
        mem_we    = 1'b0;
        tmr_start = 1'b0;

        if (sk_rise && di_s && r_q.status) r_d.rel = 1'b1;
        if (sk_fall && r_q.rel) begin
            r_d.status = 1'b0;
            r_d.rel    = 1'b0;
        end

        case (r_q.st)
            S_IDLE: begin
                if (cs_s && sk_rise && di_s) begin
                    r_d.st  = S_CMD;
                    r_d.cnt = '0;
                    r_d.sh  = '0;
                end
            end
            S_CMD: begin
                if (!cs_s) begin
                    r_d.st = S_IDLE;
                end else if (sk_rise) begin
                    r_d.sh  = full;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (int'(r_q.cnt) == fl + 1) begin
                        r_d.addr  = caddr;
                        r_d.cnt   = '0;
                        r_d.wdata = '0;
                        case (opc)
                            2'b10: begin
                                r_d.st    = S_READ;
                                r_d.raddr = caddr;
                                r_d.dummy = 1'b1;
                            end
                            2'b01: begin
                                r_d.op = OP_WORD_WR;
                                r_d.st = r_q.wen ? S_DATA : S_SKIP;
                            end
                            2'b11: begin
                                r_d.op = OP_WORD_CLR;
                                r_d.st = r_q.wen ? S_WAITCS : S_SKIP;
                            end
                            default: begin
                                case (spc)
                                    2'b11: begin
                                        r_d.wen = 1'b1;
                                        r_d.st  = S_SKIP;
                                    end
                                    2'b00: begin
                                        r_d.wen = 1'b0;
                                        r_d.st  = S_SKIP;
                                    end
                                    2'b10: begin
                                        r_d.op = OP_ALL_CLR;
                                        r_d.st = r_q.wen ? S_WAITCS : S_SKIP;
                                    end
                                    default: begin
                                        r_d.op = OP_ALL_WR;
                                        r_d.st = r_q.wen ? S_DATA : S_SKIP;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
            end
            S_DATA: begin
                if (!cs_s) begin
                    r_d.st = S_IDLE;
                end else if (sk_rise) begin
                    r_d.wdata = {r_q.wdata[14:0], di_s};
                    r_d.cnt   = r_q.cnt + 1'b1;
                    if (int'(r_q.cnt) == ww - 1) r_d.st = S_WAITCS;
                end
            end
            S_WAITCS: begin
                if (!cs_s) begin
                    tmr_start  = 1'b1;
                    r_d.st     = S_BUSY;
                    r_d.status = 1'b1;
                    r_d.rel    = 1'b0;
                end
            end
            S_BUSY: begin
                if (tmr_done) begin
                    mem_we = 1'b1;
                    r_d.st = S_IDLE;
                end
            end
            S_READ: begin
                if (!cs_s) begin
                    r_d.st = S_IDLE;
                end else if (sk_rise) begin
                    if (r_q.dummy) begin
                        r_d.dummy = 1'b0;
                        r_d.rbit  = 4'(ww - 1);
                    end else if (r_q.rbit == 4'd0) begin
                        r_d.raddr = nxt_raddr;
                        r_d.rbit  = 4'(ww - 1);
                    end else begin
                        r_d.rbit = r_q.rbit - 1'b1;
                    end
                end
            end
            default: begin
                if (!cs_s) r_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
            r_q.op <= OP_WORD_WR;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_read = (r_q.st == S_READ);
    assign in_busy = (r_q.st == S_BUSY);
    assign in_cmd  = (r_q.st == S_CMD) || (r_q.st == S_DATA);

    assign do_out = in_read ? (!r_q.dummy && rdata[r_q.rbit]) : !in_busy;
    assign do_oe  = cs && (in_read || r_q.status);
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk #(
    parameter int WCYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic cs_s,
    input logic do_out,
    input logic do_oe,
    input logic in_read,
    input logic in_busy,
    input logic in_cmd,
    input logic mem_we,
    input logic wen
);
    int bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bcnt <= 0;
        else if (in_busy) bcnt <= bcnt + 1;
        else              bcnt <= 0;
    end

    AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> wen); // R5
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (bcnt == WCYCLES - 1)); // R8
    AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n) (in_busy && do_oe) |-> !do_out); // R8
    AST_READ_LEADS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(in_read) |-> (do_oe && !do_out)); // R3
    AST_RELEASED_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n) !cs |-> !do_oe); // R12
    AST_DESELECT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n) !cs_s |=> !(in_cmd || in_read)); // R10
endmodule

bind uwire_eeprom uwire_eeprom_chk #(.WCYCLES(WCYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .cs_s   (cs_s),
    .do_out (do_out),
    .do_oe  (do_oe),
    .in_read(in_read),
    .in_busy(in_busy),
    .in_cmd (in_cmd),
    .mem_we (mem_we),
    .wen    (r_q.wen)
);

// File: tb/sim_uwire_eeprom.sv
module sim_uwire_eeprom;
    localparam int WC = 500;

    logic clk = 1'b0;
    logic rst_n, cs, sk, di, org;
    logic do_out, do_oe;
    int   nchk = 0;
    int   nerr = 0;
    bit   done = 0;
    logic [7:0] ref_mem [1024];
    bit   wen_m;

    always #10 clk = ~clk;

    uwire_eeprom #(.ABITS(10), .WCYCLES(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
        .do_out(do_out), .do_oe(do_oe)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        di = b; wt(4);
        sk = 1'b1; wt(4);
        sk = 1'b0; wt(4);
    endtask

    task automatic sel();
        cs = 1'b1; wt(4);
    endtask

    task automatic desel();
        cs = 1'b0; di = 1'b0; wt(6);
    endtask

    function automatic logic [10:0] mk_addr(input int a, input bit o, input bit dc);
        if (o) return {1'b0, dc, 9'(a)};
        return {dc, 10'(a)};
    endfunction

    function automatic logic [10:0] mk_spec(input logic [1:0] sp, input bit o);
        if (o) return {1'b0, sp, 8'h00};
        return {sp, 9'h000};
    endfunction

    function automatic logic [15:0] exp_word(input int a, input bit o);
        if (o) return {ref_mem[2*a], ref_mem[2*a+1]};
        return {8'h00, ref_mem[a]};
    endfunction

    task automatic send_cmd(input logic [1:0] opc, input logic [10:0] fld);
        int fl;
        fl = org ? 10 : 11;
        sbit(1'b1); sbit(opc[1]); sbit(opc[0]);
        for (int i = fl - 1; i >= 0; i--) sbit(fld[i]);
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = (org ? 15 : 7); i >= 0; i--) sbit(d[i]);
    endtask

    task automatic special(input logic [1:0] sp);
        sel(); send_cmd(2'b00, mk_spec(sp, org)); desel();
        if (sp == 2'b11) wen_m = 1;
        if (sp == 2'b00) wen_m = 0;
    endtask

    task automatic poll();
        sel();
        chk("R8 busy status", {14'b0, do_oe, do_out}, 16'h0002);
        wt(WC + 10);
        chk("R8 ready status", {14'b0, do_oe, do_out}, 16'h0003);
        sbit(1'b1);
        chk("R9 release", {15'b0, do_oe}, 16'h0000);
        desel();
    endtask

    task automatic apply_ref(input int kind, input int a, input logic [15:0] d);
        for (int i = 0; i < 1024; i++) begin
            if (kind == 2) ref_mem[i] = 8'hFF;
            if (kind == 3) ref_mem[i] = (org && (i % 2 == 0)) ? d[15:8] : d[7:0];
        end
        if (kind == 0 && org)  begin ref_mem[2*a] = d[15:8]; ref_mem[2*a+1] = d[7:0]; end
        if (kind == 0 && !org) ref_mem[a] = d[7:0];
        if (kind == 1 && org)  begin ref_mem[2*a] = 8'hFF; ref_mem[2*a+1] = 8'hFF; end
        if (kind == 1 && !org) ref_mem[a] = 8'hFF;
    endtask

    // kind: 0 word write, 1 word clear, 2 clear all, 3 write all
    task automatic prog(input int kind, input int a, input logic [15:0] d, input bit dc);
        sel();
        case (kind)
            0: begin send_cmd(2'b01, mk_addr(a, org, dc)); send_data(d); end
            1: send_cmd(2'b11, mk_addr(a, org, dc));
            2: send_cmd(2'b00, mk_spec(2'b10, org));
            default: begin send_cmd(2'b00, mk_spec(2'b01, org)); send_data(d); end
        endcase
        desel();
        if (wen_m) begin
            apply_ref(kind, a, d);
            poll();
        end else begin
            sel();
            chk("R5 no busy when disabled", {15'b0, do_oe}, 16'h0000);
            desel();
        end
    endtask

    task automatic rd(input int a, input int n, input bit dc, input string t1, input string t2);
        int depth;
        logic [15:0] w;
        depth = org ? 512 : 1024;
        sel();
        send_cmd(2'b10, mk_addr(a, org, dc));
        chk({t1, " leading zero"}, {14'b0, do_oe, do_out}, 16'h0002);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < (org ? 16 : 8); b++) begin
                sbit(1'b0);
                w = {w[14:0], do_out};
            end
            chk((k == 0) ? t1 : t2, w, exp_word((a + k) % depth, org));
        end
        desel();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(20240611);
        for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
        wen_m = 0;
        rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0; org = 1'b1;
        wt(5);
        rst_n = 1'b1;
        wt(3);
        chk("R1 output released after reset", {15'b0, do_oe}, 16'h0000);
        rd(0, 1, 1'b0, "R1 erased after reset", "R1");

        // disabled write is ignored
        prog(0, 5, 16'h1234, 1'b0);
        rd(5, 1, 1'b0, "R5 disabled write ignored", "R5");

        special(2'b11);
        prog(0, 5, 16'hA5C3, 1'b1);
        rd(5, 1, 1'b0, "R6 word write", "R6");
        prog(0, 5, 16'h0F0F, 1'b0);
        rd(5, 1, 1'b1, "R6 overwrite without erase", "R6");
        chk("R12 released when deselected", {15'b0, do_oe}, 16'h0000);

        // organization mapping
        org = 1'b0; wt(4);
        rd(10, 2, 1'b0, "R11 high byte", "R11 low byte");
        prog(0, 1023, 16'h005A, 1'b1);
        prog(0, 0, 16'h00C7, 1'b0);
        rd(1022, 4, 1'b1, "R4 x8 first", "R4 x8 wrap");

        // leading zeros before the start bit
        sel(); sbit(1'b0); sbit(1'b0); sbit(1'b0);
        send_cmd(2'b10, mk_addr(1023, 1'b0, 1'b0));
        begin
            logic [15:0] w;
            w = '0;
            for (int b = 0; b < 8; b++) begin sbit(1'b0); w = {w[14:0], do_out}; end
            chk("R2 leading zeros ignored", w, 16'h005A);
        end
        desel();

        org = 1'b1; wt(4);
        prog(0, 511, 16'hBEEF, 1'b0);
        prog(0, 0, 16'h4321, 1'b1);
        rd(510, 4, 1'b0, "R4 x16 first", "R4 x16 wrap");

        // abort: partial write data
        sel(); send_cmd(2'b01, mk_addr(5, 1'b1, 1'b0));
        sbit(1'b1); sbit(1'b1); sbit(1'b0);
        desel();
        sel();
        chk("R10 aborted write starts no busy", {15'b0, do_oe}, 16'h0000);
        desel();
        rd(5, 1, 1'b0, "R10 aborted write no change", "R10");

        // command during busy is ignored
        sel(); send_cmd(2'b01, mk_addr(7, 1'b1, 1'b0)); send_data(16'h7777); desel();
        apply_ref(0, 7, 16'h7777);
        sel(); send_cmd(2'b01, mk_addr(7, 1'b1, 1'b0)); send_data(16'h1111); desel();
        wt(WC + 10);
        rd(7, 1, 1'b0, "R8 command during busy ignored", "R8");

        // clears and write-all
        prog(1, 7, 16'h0000, 1'b0);
        rd(7, 1, 1'b0, "R7 word clear", "R7");
        prog(3, 0, 16'h3CA1, 1'b0);
        rd(100, 2, 1'b0, "R7 write all", "R7 write all next");
        prog(2, 0, 16'h0000, 1'b0);
        rd(300, 2, 1'b0, "R7 clear all", "R7 clear all next");

        // write disable
        special(2'b00);
        prog(0, 9, 16'h5555, 1'b0);
        rd(9, 1, 1'b0, "R5 write after disable ignored", "R5");
        special(2'b11);

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            int kind, a, n;
            logic [15:0] d;
            org = 1'($urandom_range(0, 1)); wt(4);
            a = org ? $urandom_range(0, 511) : $urandom_range(0, 1023);
            d = 16'($urandom);
            kind = $urandom_range(0, 9);
            n = $urandom_range(1, 3);
            if (kind < 4)       prog(0, a, d, 1'($urandom_range(0, 1)));
            else if (kind == 4) prog(1, a, d, 1'b0);
            else                rd(a, n, 1'($urandom_range(0, 1)), "R3 random read", "R4 random sequential");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule